// File: doc/BRIEF.md
# Three-Wire Synthesizer Control Loader

This block is a serial slave that takes a clock, a data line and a latch-enable line from a host, all sampled on a faster system clock. While latch-enable is low, each rising edge of the serial clock shifts one data bit, most significant bit first, into a 20-bit frame register. When latch-enable rises, the two lowest frame bits choose one of four control registers, and the rest of the frame is copied into it. The registers drive the parallel settings of a frequency synthesizer and an offset-calibration sequencer: the reference divider, the swallow and main counts, the operating mode and the calibration settings.

After reset the mode register has to be loaded first. Frames sent to any other register before that are dropped. A status output is chosen by three mode bits. It can carry a lock indication, a forced low, the divided reference, the divided oscillator, or a serial readback of the frame register. The readback shows the frame's top bit once latch-enable falls, then moves on one bit at each rising serial clock.

Top module: `tw_prog_top`

## Requirements
- R1: After reset every parallel output is zero, and the status output follows `lock_det_in`, because the select code resets to 000.
- R2: Data is sampled only on a rising serial-clock edge while latch-enable is low, and it fills the frame register MSB first. When latch-enable rises, frame bits [1:0] give the target address: 00 is mode, 01 is reference divider, 10 is counts, 11 is calibration.
- R3: A mode write stores frame bits [17:2] as mode bits M[15:0]. `pll_enable`=M[0]. `presc_wide`=M[2] (0 selects 16/17, 1 selects 32/33). `cp_current`=M[4:3]. `cp_polarity`=M[6:5].
- R4: A reference-divider write loads `ref_divider` with frame bits [16:2].
- R5: A counts write loads `swallow_cnt` with frame bits [8:2] and `main_cnt` with frame bits [19:9].
- R6: A calibration write loads `cal_clk_div` with frame bits [8:2] (C[6:0]) and `dc_hold_en` with frame bit 13 (C[11]).
- R7: Until a mode write has happened after reset, writes to addresses 01, 10 and 11 leave their registers unchanged.
- R8: Rising serial-clock edges while latch-enable is high do not change the frame register. Raising latch-enable again without new clocks rewrites the same value.
- R9: The status select is {M[13],M[8],M[7]}. 00x gives `lock_det_in`. 01x gives 0. 10x gives serial readback. 110 gives `ref_div_in`. 111 gives `vco_div_in`.
- R10: In readback, the frame MSB appears on the status output after latch-enable falls. After the k-th following rising serial clock, the output shows the bit that was k places below the MSB.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_clk | input | 1 | Serial clock |
| ser_dat | input | 1 | Serial data |
| ser_le | input | 1 | Latch enable, active low shifting |
| lock_det_in | input | 1 | Lock indication for the status output |
| ref_div_in | input | 1 | Divided reference waveform |
| vco_div_in | input | 1 | Divided oscillator waveform |
| pll_enable | output | 1 | Synthesizer enable |
| presc_wide | output | 1 | Prescaler select |
| cp_current | output | 2 | Charge-pump current code |
| cp_polarity | output | 2 | Charge-pump sign code |
| ref_divider | output | 15 | Reference divide value |
| swallow_cnt | output | 7 | Swallow count |
| main_cnt | output | 11 | Main count |
| cal_clk_div | output | 7 | Calibration clock divider |
| dc_hold_en | output | 1 | Baseband DC-hold enable |
| status_out | output | 1 | Multiplexed status output |

## Verification
The hardest state to reach is the serial readback. The select code must first be loaded through a mode frame. Only after that can a new frame be opened, and its bits are seen one at a time as they leave the register. The bench loads a readback select using a mode frame with a distinctive pattern. It then resends that same frame and compares the status output after each serial clock with the previous frame, shifted by the edge count. The rule that a latch-enable pulse with no clocks rewrites the held frame is used to show that clocks sent while latch-enable is high were dropped.

// File: rtl/tw_prog_pkg.sv
package tw_prog_pkg;
    localparam int FRAME_W  = 20;
    localparam int ADDR_W   = 2;
    localparam int PAY_W    = FRAME_W - ADDR_W;
    localparam int MODE_W   = 16;
    localparam int RDIV_W   = 15;
    localparam int ACNT_W   = 7;
    localparam int BCNT_W   = 11;
    localparam int NCNT_W   = ACNT_W + BCNT_W;
    localparam int CAL_W    = 12;
    localparam int CDIV_W   = 7;

    localparam int M_PLL_EN = 0;
    localparam int M_PRESC  = 2;
    localparam int M_CP_LO  = 3;
    localparam int M_SGN_LO = 5;
    localparam int M_SEL_A  = 7;
    localparam int M_SEL_B  = 8;
    localparam int M_SEL_C  = 13;
    localparam int C_HOLD   = 11;

    typedef enum logic [ADDR_W-1:0] {
        ADR_MODE = 2'b00,
        ADR_RDIV = 2'b01,
        ADR_NCNT = 2'b10,
        ADR_CAL  = 2'b11
    } tw_addr_e;
endpackage

// File: rtl/tw_edge_sync.sv
module tw_edge_sync #(
    parameter int N      = 3,
    parameter int STAGES = 2,
    parameter logic [N-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] raw,
    output logic [N-1:0] lvl,
    output logic [N-1:0] rise,
    output logic [N-1:0] fall
);
    typedef struct packed {
        logic [STAGES-1:0][N-1:0] chain;
        logic [N-1:0]             prev;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.chain[0] = raw;
        for (int i = 1; i < STAGES; i++) begin
            st_d.chain[i] = st_q.chain[i-1];
        end
        st_d.prev = st_q.chain[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.chain <= {STAGES{RST_VAL}};
            st_q.prev  <= RST_VAL;
        end else begin
            st_q <= st_d;
        end
    end

    assign lvl  = st_q.chain[STAGES-1];
    assign rise = lvl & ~st_q.prev;
    assign fall = ~lvl & st_q.prev;

    a_r2_edge_single: assert property (@(posedge clk) disable iff (!rst_n)
        (rise != '0) |=> ((rise & $past(rise)) == '0));
endmodule

// File: rtl/tw_shift_frame.sv
module tw_shift_frame
    import tw_prog_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sclk_rise,
    input  logic               sdat,
    input  logic               le_lvl,
    input  logic               le_fall,
    output logic [FRAME_W-1:0] frame,
    output logic               rb_bit
);
    typedef struct packed {
        logic [FRAME_W-1:0] sr;
        logic               rb;
    } shf_t;

    shf_t sh_d, sh_q;
    logic shift_en;

    always_comb begin
        sh_d     = sh_q;
        shift_en = sclk_rise && !le_lvl;
        if (shift_en) begin
            sh_d.sr = {sh_q.sr[FRAME_W-2:0], sdat};
            sh_d.rb = sh_q.sr[FRAME_W-2];
        end else if (le_fall) begin
            sh_d.rb = sh_q.sr[FRAME_W-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign frame  = sh_q.sr;
    assign rb_bit = sh_q.rb;

    a_r8_hold_le_high: assert property (@(posedge clk) disable iff (!rst_n)
        le_lvl |=> $stable(sh_q.sr));
    a_r10_rb_msb_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        (le_fall && !sclk_rise) |=> (sh_q.rb == $past(sh_q.sr[FRAME_W-1])));
endmodule

// File: rtl/tw_reg_bank.sv
module tw_reg_bank
    import tw_prog_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_stb,
    input  logic [FRAME_W-1:0] frame,
    output logic [MODE_W-1:0]  mode,
    output logic [RDIV_W-1:0]  rdiv,
    output logic [NCNT_W-1:0]  ncnt,
    output logic [CAL_W-1:0]   cal
);
    typedef struct packed {
        logic [MODE_W-1:0] mode;
        logic [RDIV_W-1:0] rdiv;
        logic [NCNT_W-1:0] ncnt;
        logic [CAL_W-1:0]  cal;
        logic              seen;
    } bank_t;

    bank_t bk_d, bk_q;
    tw_addr_e adr;

    assign adr = tw_addr_e'(frame[ADDR_W-1:0]);

    always_comb begin
        bk_d = bk_q;
        if (wr_stb) begin
            unique case (adr)
                ADR_MODE: begin
                    bk_d.mode = frame[ADDR_W +: MODE_W];
                    bk_d.seen = 1'b1;
                end
                ADR_RDIV: if (bk_q.seen) bk_d.rdiv = frame[ADDR_W +: RDIV_W];
                ADR_NCNT: if (bk_q.seen) bk_d.ncnt = frame[ADDR_W +: NCNT_W];
                ADR_CAL:  if (bk_q.seen) bk_d.cal  = frame[ADDR_W +: CAL_W];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bk_q <= '0;
        else        bk_q <= bk_d;
    end

    assign mode = bk_q.mode;
    assign rdiv = bk_q.rdiv;
    assign ncnt = bk_q.ncnt;
    assign cal  = bk_q.cal;

    a_r7_locked_before_mode: assert property (@(posedge clk) disable iff (!rst_n)
        !bk_q.seen |=> ($stable(bk_q.rdiv) && $stable(bk_q.ncnt) && $stable(bk_q.cal)));
    a_r3_mode_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && frame[ADDR_W-1:0] == 2'b00) |=> (bk_q.mode == $past(frame[ADDR_W +: MODE_W])));
    a_r2_quiet_without_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_stb |=> $stable(bk_q));
endmodule

// File: rtl/tw_stat_mux.sv
module tw_stat_mux (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] sel,
    input  logic       lock_i,
    input  logic       rb_i,
    input  logic       refd_i,
    input  logic       vcod_i,
    output logic       stat
);
    logic stat_d, stat_q;

    always_comb begin
        unique casez (sel)
            3'b00?:  stat_d = lock_i;
            3'b01?:  stat_d = 1'b0;
            3'b10?:  stat_d = rb_i;
            3'b110:  stat_d = refd_i;
            default: stat_d = vcod_i;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stat_q <= 1'b0;
        else        stat_q <= stat_d;
    end

    assign stat = stat_q;

    a_r9_forced_low: assert property (@(posedge clk) disable iff (!rst_n)
        (sel[2:1] == 2'b01) |=> !stat_q);
    a_r9_lock_path: assert property (@(posedge clk) disable iff (!rst_n)
        (sel[2:1] == 2'b00) |=> (stat_q == $past(lock_i)));
endmodule

// File: rtl/tw_prog_top.sv
module tw_prog_top
    import tw_prog_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_clk,
    input  logic              ser_dat,
    input  logic              ser_le,
    input  logic              lock_det_in,
    input  logic              ref_div_in,
    input  logic              vco_div_in,
    output logic              pll_enable,
    output logic              presc_wide,
    output logic [1:0]        cp_current,
    output logic [1:0]        cp_polarity,
    output logic [RDIV_W-1:0] ref_divider,
    output logic [ACNT_W-1:0] swallow_cnt,
    output logic [BCNT_W-1:0] main_cnt,
    output logic [CDIV_W-1:0] cal_clk_div,
    output logic              dc_hold_en,
    output logic              status_out
);
    localparam int IX_CLK = 0;
    localparam int IX_DAT = 1;
    localparam int IX_LE  = 2;

    logic [2:0]         s_lvl, s_rise, s_fall;
    logic [FRAME_W-1:0] frame;
    logic               rb_bit;
    logic [MODE_W-1:0]  mode;
    logic [NCNT_W-1:0]  ncnt;
    logic [CAL_W-1:0]   cal;

    tw_edge_sync #(.N(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .raw  ({ser_le, ser_dat, ser_clk}),
        .lvl  (s_lvl),
        .rise (s_rise),
        .fall (s_fall)
    );

    tw_shift_frame u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .sclk_rise(s_rise[IX_CLK]),
        .sdat     (s_lvl[IX_DAT]),
        .le_lvl   (s_lvl[IX_LE]),
        .le_fall  (s_fall[IX_LE]),
        .frame    (frame),
        .rb_bit   (rb_bit)
    );

    tw_reg_bank u_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_stb(s_rise[IX_LE]),
        .frame (frame),
        .mode  (mode),
        .rdiv  (ref_divider),
        .ncnt  (ncnt),
        .cal   (cal)
    );

    tw_stat_mux u_stat (
        .clk   (clk),
        .rst_n (rst_n),
        .sel   ({mode[M_SEL_C], mode[M_SEL_B], mode[M_SEL_A]}),
        .lock_i(lock_det_in),
        .rb_i  (rb_bit),
        .refd_i(ref_div_in),
        .vcod_i(vco_div_in),
        .stat  (status_out)
    );

    assign pll_enable  = mode[M_PLL_EN];
    assign presc_wide  = mode[M_PRESC];
    assign cp_current  = mode[M_CP_LO +: 2];
    assign cp_polarity = mode[M_SGN_LO +: 2];
    assign swallow_cnt = ncnt[ACNT_W-1:0];
    assign main_cnt    = ncnt[NCNT_W-1:ACNT_W];
    assign cal_clk_div = cal[CDIV_W-1:0];
    assign dc_hold_en  = cal[C_HOLD];

    logic unused_bits;
    assign unused_bits = ^{s_rise[IX_DAT], s_fall[IX_DAT], s_fall[IX_CLK], s_lvl[IX_CLK],
                           mode[1], mode[MODE_W-1:M_SEL_C+1], mode[M_SEL_C-1:M_SEL_B+1],
                           cal[C_HOLD-1:CDIV_W]};
endmodule

// File: tb/tb_tw_prog_top.sv
module tb_tw_prog_top;
    logic clk = 0, rst_n = 0;
    logic ser_clk = 0, ser_dat = 0, ser_le = 1;
    logic lock_det_in = 1, ref_div_in = 0, vco_div_in = 0;
    logic pll_enable, presc_wide, dc_hold_en, status_out;
    logic [1:0] cp_current, cp_polarity;
    logic [14:0] ref_divider;
    logic [6:0] swallow_cnt, cal_clk_div;
    logic [10:0] main_cnt;
    int checks = 0, errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    tw_prog_top dut (.*);

    task automatic wclk(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [19:0] mk(logic [1:0] adr, logic [17:0] pay);
        return {pay, adr};
    endfunction

    task automatic bit_out(logic b);
        ser_dat = b; wclk(4);
        ser_clk = 1; wclk(4);
        ser_clk = 0; wclk(4);
    endtask

    task automatic send(logic [19:0] f);
        ser_le = 0; wclk(8);
        for (int i = 19; i >= 0; i--) bit_out(f[i]);
        ser_le = 1; wclk(8);
    endtask

    task automatic t_reset();
        check("R1 ref_divider", ref_divider, 0);
        check("R1 counts", {main_cnt, swallow_cnt}, 0);
        check("R1 mode fields", {pll_enable, presc_wide, cp_current, cp_polarity}, 0);
        check("R1 cal", {cal_clk_div, dc_hold_en}, 0);
        check("R1 status lock", status_out, 1);
    endtask

    task automatic t_before_mode();
        send(mk(2'b01, 18'h01234));
        check("R7 rdiv ignored", ref_divider, 0);
        send(mk(2'b11, 18'h0087F));
        check("R7 cal ignored", {cal_clk_div, dc_hold_en}, 0);
        send(mk(2'b10, 18'h3FFFF));
        check("R7 counts ignored", {main_cnt, swallow_cnt}, 0);
    endtask

    task automatic t_mode();
        send(mk(2'b00, 18'd53));
        check("R3 pll_enable", pll_enable, 1);
        check("R3 presc_wide", presc_wide, 1);
        check("R3 cp_current", cp_current, 2'b10);
        check("R3 cp_polarity", cp_polarity, 2'b01);
        check("R9 status lock 000", status_out, 1);
    endtask

    task automatic t_regs();
        send(mk(2'b01, {3'b000, 15'h5A3C}));
        check("R4 ref_divider", ref_divider, 15'h5A3C);
        check("R2 mode untouched", {pll_enable, cp_current}, 3'b110);
        send(mk(2'b10, {11'h4D3, 7'h55}));
        check("R5 swallow_cnt", swallow_cnt, 7'h55);
        check("R5 main_cnt", main_cnt, 11'h4D3);
        send(mk(2'b11, {6'h0, 1'b1, 4'h0, 7'h6B}));
        check("R6 cal_clk_div", cal_clk_div, 7'h6B);
        check("R6 dc_hold_en", dc_hold_en, 1);
        send(mk(2'b11, {6'h0, 1'b0, 4'hF, 7'h11}));
        check("R6 cal_clk_div 2", cal_clk_div, 7'h11);
        check("R6 dc_hold_en off", dc_hold_en, 0);
    endtask

    task automatic t_le_high();
        for (int i = 0; i < 6; i++) bit_out(1'b1);
        ser_le = 0; wclk(8); ser_le = 1; wclk(8);
        check("R8 cal kept", cal_clk_div, 7'h11);
        check("R8 hold kept", dc_hold_en, 0);
        check("R8 rdiv kept", ref_divider, 15'h5A3C);
    endtask

    task automatic t_status();
        send(mk(2'b00, 18'h00100));
        lock_det_in = 1; wclk(4);
        check("R9 forced low 01x", status_out, 0);
        send(mk(2'b00, 18'h02100));
        ref_div_in = 1; vco_div_in = 0; wclk(4);
        check("R9 ref 110 hi", status_out, 1);
        ref_div_in = 0; wclk(4);
        check("R9 ref 110 lo", status_out, 0);
        send(mk(2'b00, 18'h02180));
        vco_div_in = 1; wclk(4);
        check("R9 vco 111", status_out, 1);
        vco_div_in = 0; wclk(4);
        check("R9 vco 111 lo", status_out, 0);
    endtask

    task automatic t_readback();
        logic [19:0] f;
        f = mk(2'b00, 18'h2A000);
        send(f);
        ser_le = 0; wclk(8);
        check("R10 msb on le fall", status_out, f[19]);
        for (int k = 1; k < 20; k++) begin
            bit_out(f[20-k]);
            check($sformatf("R10 bit %0d", k), status_out, f[19-k]);
        end
        bit_out(f[0]);
        ser_le = 1; wclk(8);
        check("R10 mode stable", {cp_current, pll_enable}, 3'b000);
    endtask

    initial begin
        wclk(4); rst_n = 1; wclk(8);
        t_reset();
        t_before_mode();
        t_mode();
        t_regs();
        t_le_high();
        t_status();
        t_readback();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule